// File: doc/BRIEF.md
# Legacy Serial Port Register Interface

This block is the byte-wide register file of a PC-style serial port that has no FIFOs. A host reaches eight register offsets over a simple single-cycle read/write bus. A transmitted byte leaves on a one-cycle strobe with its data. A received byte arrives on a valid/data input, together with a small kind code. That code either carries a normal byte or raises or drops a break condition. One interrupt line reports the pending causes.

The transmitter is modelled as always idle, so line status always reports both transmit-side ready bits. The interrupt-identification register behaves as a small set of cause bits. Reading the data register clears the receive cause. Reading the identification register clears the transmit cause. Whenever no cause is left, the register is forced to the "nothing pending" value 0x01. Setting the divisor-latch-access bit in line control swaps offsets 0 and 1 over to the two divisor bytes.

Top module: `uart_regif`

## Requirements
- R1: After reset the divisor low byte reads 1, data, interrupt enable, line control, modem control and scratch read 0, identification reads 0x01, line status reads 0x60 and irq_o is low.
- R2: While line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte, and a write to offset 0 emits no transmit strobe.
- R3: A write to offset 0 with line-control bit 7 clear drives tx_valid_o high for exactly the next cycle, with the written byte on tx_data_o. If interrupt-enable bit 1 is set, the write also sets identification bit 1 and clears bit 0.
- R4: Line status (offset 5) always reads with bits 5 and 6 set, and writes to offsets 5 and 6 change nothing that can be read.
- R5: Modem status (offset 6) reads 0xB0: bits 7, 5 and 4 are forced high.
- R6: A received byte sets line-status bit 0. If interrupt-enable bit 0 is set, it also sets identification bit 2 and clears identification bit 0.
- R7: A data read while line-status bit 0 is set returns the held byte, then clears the held byte to 0 and clears line-status bit 0. A data read while bit 0 is clear returns the held value and changes nothing in line status.
- R8: Every data read clears identification bit 2, and an identification value left at 0 becomes 0x01.
- R9: An identification read (offset 2) returns the current value, then clears bit 1 and applies the same zero-to-0x01 rule. A write to offset 2 has no readable effect.
- R10: Writing interrupt enable with bit 1 set immediately sets identification bit 1 and clears bit 0.
- R11: rx_kind_i 1 (break set) sets line-status bit 4, and kind 2 (break clear) clears it. For any nonzero kind the byte delivered is 0x00, whatever rx_data_i carries. Kind 0 delivers rx_data_i.
- R12: A byte received while line-status bit 0 is still set sets line-status bit 1 (overrun) and replaces the held byte. A line-status read clears bit 1.
- R13: irq_o is high exactly while identification bit 0 is 0.
- R14: Line control, modem control and scratch read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| rx_valid_i | input | 1 | Receive event this cycle |
| rx_kind_i | input | 2 | 0 data, 1 break set, 2 break clear |
| rx_data_i | input | 8 | Received byte for kind 0 |
| tx_valid_o | output | 1 | Transmit strobe, one cycle |
| tx_data_o | output | 8 | Transmitted byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Receive traffic is applied in three shapes: a single byte read out promptly, two back-to-back bytes with no read between them, and break set and clear commands carrying a nonzero payload. These separate correct consumption from overrun, and show that the payload is discarded on break kinds. Transmit writes are made with the transmit interrupt enabled, with it disabled, and with the divisor latch selected. This tells apart a real transmit from a divisor access and from a write that should raise no cause. Identification reads taken before and after each data read or identification read show which access clears which cause, and that the register always falls back to 0x01.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;

  typedef enum logic [AW-1:0] {
    OFF_DATA = 3'd0,
    OFF_IER  = 3'd1,
    OFF_IIR  = 3'd2,
    OFF_LCR  = 3'd3,
    OFF_MCR  = 3'd4,
    OFF_LSR  = 3'd5,
    OFF_MSR  = 3'd6,
    OFF_SCR  = 3'd7
  } reg_off_e;

  typedef enum logic [1:0] {
    RX_BYTE    = 2'd0,
    RX_BRK_SET = 2'd1,
    RX_BRK_CLR = 2'd2
  } rx_kind_e;

  localparam int unsigned LCR_DLAB_BIT = 7;
  localparam int unsigned IER_RX_BIT   = 0;
  localparam int unsigned IER_TX_BIT   = 1;
  localparam int unsigned ID_W         = 3;   // no-pending, tx cause, rx cause
  localparam logic [DW-1:0] LSR_TX_IDLE = 8'h60;
  localparam logic [DW-1:0] MSR_FORCED  = 8'hB0;
  localparam logic [DW-1:0] DIV_LO_RST  = 8'h01;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [1:0]    rx_kind_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          consume_i,
  input  logic          lsr_rd_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o,
  output logic          ovr_o,
  output logic          brk_o
);
  logic [DW-1:0] data_q;
  logic rdy_q, ovr_q, brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      if (consume_i && rdy_q) begin
        data_q <= '0;
        rdy_q  <= 1'b0;
      end
      if (lsr_rd_i) ovr_q <= 1'b0;
      // arrival takes priority over a same-cycle consume
      if (rx_valid_i) begin
        rdy_q  <= 1'b1;
        data_q <= (rx_kind_i == RX_BYTE) ? rx_data_i : '0;
        if (rdy_q && !consume_i) ovr_q <= 1'b1;
        if (rx_kind_i == RX_BRK_SET) brk_q <= 1'b1;
        else if (rx_kind_i == RX_BRK_CLR) brk_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign brk_o  = brk_q;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_data_i,
  input  logic          rd_iir_i,
  input  logic          set_rx_i,
  input  logic          set_tx_i,
  output logic [DW-1:0] iir_o
);
  logic [ID_W-1:0] id_q, id_d;

  always_comb begin
    id_d = id_q;
    if (rd_data_i) id_d[2] = 1'b0;
    if (rd_iir_i)  id_d[1] = 1'b0;
    if (id_d == '0) id_d = 3'b001;
    if (set_rx_i) begin
      id_d[2] = 1'b1;
      id_d[0] = 1'b0;
    end
    if (set_tx_i) begin
      id_d[1] = 1'b1;
      id_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= 3'b001;
    else         id_q <= id_d;
  end

  assign iir_o = {{(DW-ID_W){1'b0}}, id_q};
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_valid_i,
  input  logic [1:0]    rx_kind_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_o
);
  logic [DW-1:0] lcr_q, ier_q, mcr_q, scr_q, div_lo_q, div_hi_q, tx_data_q;
  logic tx_valid_q;
  logic dlab, wr, rd;
  logic [DW-1:0] rx_byte, iir;
  logic rx_rdy, rx_ovr, rx_brk;
  logic set_tx;

  assign dlab = lcr_q[LCR_DLAB_BIT];
  assign wr   = req_i && we_i;
  assign rd   = req_i && !we_i;

  logic rd_data, rd_iir, rd_lsr, wr_data, wr_ier;
  assign rd_data = rd && (addr_i == OFF_DATA) && !dlab;
  assign rd_iir  = rd && (addr_i == OFF_IIR);
  assign rd_lsr  = rd && (addr_i == OFF_LSR);
  assign wr_data = wr && (addr_i == OFF_DATA) && !dlab;
  assign wr_ier  = wr && (addr_i == OFF_IER) && !dlab;

  assign set_tx = (wr_ier && wdata_i[IER_TX_BIT]) || (wr_data && ier_q[IER_TX_BIT]);

  uart_rx_hold u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_kind_i  (rx_kind_i),
    .rx_data_i  (rx_data_i),
    .consume_i  (rd_data),
    .lsr_rd_i   (rd_lsr),
    .data_o     (rx_byte),
    .rdy_o      (rx_rdy),
    .ovr_o      (rx_ovr),
    .brk_o      (rx_brk)
  );

  uart_irq_ident u_id (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_data_i (rd_data),
    .rd_iir_i  (rd_iir),
    .set_rx_i  (rx_valid_i && ier_q[IER_RX_BIT]),
    .set_tx_i  (set_tx),
    .iir_o     (iir)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q      <= '0;
      ier_q      <= '0;
      mcr_q      <= '0;
      scr_q      <= '0;
      div_lo_q   <= DIV_LO_RST;
      div_hi_q   <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= wr_data;
      if (wr_data) tx_data_q <= wdata_i;
      if (wr) begin
        unique case (addr_i)
          OFF_DATA: if (dlab) div_lo_q <= wdata_i;
          OFF_IER:  if (dlab) div_hi_q <= wdata_i; else ier_q <= wdata_i;
          OFF_LCR:  lcr_q <= wdata_i;
          OFF_MCR:  mcr_q <= wdata_i;
          OFF_SCR:  scr_q <= wdata_i;
          default:  ;  // fifo control, line and modem status: discarded
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_DATA: rdata_o = dlab ? div_lo_q : rx_byte;
      OFF_IER:  rdata_o = dlab ? div_hi_q : ier_q;
      OFF_IIR:  rdata_o = iir;
      OFF_LCR:  rdata_o = lcr_q;
      OFF_MCR:  rdata_o = mcr_q;
      OFF_LSR:  rdata_o = LSR_TX_IDLE | {3'b000, rx_brk, 2'b00, rx_ovr, rx_rdy};
      OFF_MSR:  rdata_o = MSR_FORCED;
      default:  rdata_o = scr_q;
    endcase
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
  assign irq_o      = ~iir[0];
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          rx_valid_i,
  input logic          tx_valid_o,
  input logic [DW-1:0] tx_data_o,
  input logic          irq_o,
  input logic          dlab,
  input logic [DW-1:0] ier_q,
  input logic          rx_rdy
);
  a_r3_tx_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_DATA && !dlab) |=> (tx_valid_o && tx_data_o == $past(wdata_i)));

  a_r2_div_no_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_DATA && dlab) |=> !tx_valid_o);

  a_r4_lsr_tx_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_LSR) |-> (rdata_o[6] && rdata_o[5]));

  a_r5_msr_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFF_MSR) |-> (rdata_o[7] && rdata_o[5] && rdata_o[4]));

  a_r6_rx_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_rdy);

  a_r13_rx_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && ier_q[IER_RX_BIT]) |=> irq_o);
endmodule

bind uart_regif uart_regif_chk u_chk (.*);

// File: tb/tb_uart_regif.sv
`timescale 1ns/1ps
module tb_uart_regif;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rx_valid = 0;
  logic [1:0] rx_kind = '0;
  logic [7:0] rx_data = '0;
  logic tx_valid, irq;
  logic [7:0] tx_data;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  uart_regif dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_kind_i(rx_kind),
    .rx_data_i(rx_data), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #0.5 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rx_push(input logic [1:0] k, input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_kind = k; rx_data = d;
    @(negedge clk); rx_valid = 0; rx_kind = '0; rx_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd_chk("R1 data", 3'd0, 8'h00);
    rd_chk("R1 ier", 3'd1, 8'h00);
    rd_chk("R1 iir", 3'd2, 8'h01);
    rd_chk("R1 lcr", 3'd3, 8'h00);
    rd_chk("R1 mcr", 3'd4, 8'h00);
    rd_chk("R1 lsr", 3'd5, 8'h60);
    rd_chk("R1 scr", 3'd7, 8'h00);
    bus_wr(3'd3, 8'h80);
    rd_chk("R1 div_lo", 3'd0, 8'h01);
    rd_chk("R1 div_hi", 3'd1, 8'h00);
    bus_wr(3'd3, 8'h00);
  endtask

  task automatic t_divisor;
    bus_wr(3'd3, 8'h83);
    bus_wr(3'd0, 8'h0C);
    chk("R2 no tx on divisor write", {7'd0, tx_valid}, 8'h00);
    bus_wr(3'd1, 8'h02);
    rd_chk("R2 div_lo", 3'd0, 8'h0C);
    rd_chk("R2 div_hi", 3'd1, 8'h02);
    bus_wr(3'd3, 8'h03);
    rd_chk("R2 ier untouched", 3'd1, 8'h00);
    rd_chk("R14 lcr", 3'd3, 8'h03);
  endtask

  task automatic t_tx;
    bus_wr(3'd0, 8'h41);
    chk("R3 tx strobe", {7'd0, tx_valid}, 8'h01);
    chk("R3 tx data", tx_data, 8'h41);
    @(negedge clk);
    chk("R3 strobe one cycle", {7'd0, tx_valid}, 8'h00);
    rd_chk("R3 no cause when disabled", 3'd2, 8'h01);
    bus_wr(3'd1, 8'h02);
    chk("R10 irq on enable", {7'd0, irq}, 8'h01);
    rd_chk("R10 iir tx cause", 3'd2, 8'h02);
    rd_chk("R9 cleared after read", 3'd2, 8'h01);
    chk("R13 irq low", {7'd0, irq}, 8'h00);
    bus_wr(3'd0, 8'h5C);
    chk("R3 tx data enabled", tx_data, 8'h5C);
    chk("R13 irq high", {7'd0, irq}, 8'h01);
    rd_chk("R3 iir after write", 3'd2, 8'h02);
    bus_wr(3'd1, 8'h00);
  endtask

  task automatic t_rx;
    bus_wr(3'd1, 8'h01);
    rx_push(2'd0, 8'h5A);
    chk("R6 irq", {7'd0, irq}, 8'h01);
    rd_chk("R6 lsr ready", 3'd5, 8'h61);
    rd_chk("R6 iir rx", 3'd2, 8'h04);
    rd_chk("R9 iir read keeps rx cause", 3'd2, 8'h04);
    rd_chk("R7 data", 3'd0, 8'h5A);
    rd_chk("R8 iir back to none", 3'd2, 8'h01);
    chk("R13 irq cleared", {7'd0, irq}, 8'h00);
    rd_chk("R7 lsr cleared", 3'd5, 8'h60);
    rd_chk("R7 data zero after consume", 3'd0, 8'h00);
    bus_wr(3'd1, 8'h00);
    rx_push(2'd0, 8'h33);
    chk("R6 no irq when disabled", {7'd0, irq}, 8'h00);
    rd_chk("R6 iir no cause", 3'd2, 8'h01);
    rd_chk("R7 data disabled", 3'd0, 8'h33);
  endtask

  task automatic t_overrun;
    rx_push(2'd0, 8'h11);
    rx_push(2'd0, 8'h22);
    rd_chk("R12 overrun set", 3'd5, 8'h63);
    rd_chk("R12 overrun cleared by read", 3'd5, 8'h61);
    rd_chk("R12 latest byte held", 3'd0, 8'h22);
    rd_chk("R12 lsr idle", 3'd5, 8'h60);
  endtask

  task automatic t_break;
    rx_push(2'd1, 8'hEE);
    rd_chk("R11 break set", 3'd5, 8'h71);
    rd_chk("R11 zero byte on set", 3'd0, 8'h00);
    rd_chk("R11 break persists", 3'd5, 8'h70);
    rx_push(2'd2, 8'h99);
    rd_chk("R11 break cleared", 3'd5, 8'h61);
    rd_chk("R11 zero byte on clear", 3'd0, 8'h00);
  endtask

  task automatic t_misc;
    bus_wr(3'd5, 8'hFF);
    rd_chk("R4 lsr write ignored", 3'd5, 8'h60);
    bus_wr(3'd6, 8'h00);
    rd_chk("R5 msr", 3'd6, 8'hB0);
    bus_wr(3'd2, 8'hC7);
    rd_chk("R9 fifo write no effect", 3'd2, 8'h01);
    bus_wr(3'd4, 8'h1F);
    rd_chk("R14 mcr", 3'd4, 8'h1F);
    bus_wr(3'd7, 8'hA5);
    rd_chk("R14 scr", 3'd7, 8'hA5);
  endtask

  initial begin
    fork
      begin
        #20 rst_n = 1'b1;
        t_reset();
        t_divisor();
        t_tx();
        t_rx();
        t_overrun();
        t_break();
        t_misc();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule